// File: doc/BRIEF.md
# Coprocessor Write-Masked Control Register

This block is a 16-bit memory-mapped control register for a coprocessor. Its lower byte holds six control bits, and its upper byte holds a companion mask bit for each one. A bus write changes a control bit only when the write also sets that bit's mask. Because of this, several software agents can each change a single bit without reading the register first, and no read-modify-write race can occur.

The register gates the coprocessor's incoming service requests and stalls the core when the debug host freezes the system. It also holds a debug-mode bit, which software and breakpoint pulses can both set. A software-error flag is set only by hardware and cleared only by software, and it raises an interrupt when interrupt-enable is set. The core, the interrupt controller and the breakpoint logic are outside the block and reach it as input pulses.

Top module: `cpctl_reg`

## Requirements
- R1: The control bits sit in the lower byte: bit 0 error flag, bit 1 flag-test, bit 2 interrupt-enable, bit 3 debug-mode, bit 4 halt-in-freeze, bit 5 request-enable. The mask for control bit i is write-data bit 8+i. A write with wr_en=1 and both byte strobes set updates control bit i only when its mask bit is 1. The change shows on rd_data after the next rising clock edge.
- R2: rd_data bits 15:6 always read 0, so every mask bit reads back as 0.
- R3: A masked write of 0 to the error flag clears it. A masked write of 1, or an unmasked write, leaves it unchanged. A sw_err_evt pulse sets it.
- R4: Flag-test and interrupt-enable can each be set and cleared through their own masks, and neither write affects the other bits.
- R5: req_out equals req_in while request-enable is 1 and is all zeros while it is 0, in the same cycle.
- R6: core_stall is 1 exactly when halt-in-freeze is 1 and freeze_in is 1.
- R7: Debug-mode is set by a sw_bkpt or tag_bkpt pulse. A masked write of 1 sets it and a masked write of 0 clears it. dbg_mode shows its value.
- R8: freeze_in and sw_err_evt never change debug-mode.
- R9: If a hardware set-event and a masked software clear hit the same bit in one cycle, the bit ends up 1. This applies to both debug-mode and the error flag.
- R10: err_irq equals error flag AND interrupt-enable.
- R11: Synchronous active-high rst clears every control bit to 0.
- R12: A write with either byte strobe low changes no control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write access |
| wr_be | input | 2 | Byte-lane strobes (0 = control byte, 1 = mask byte) |
| wr_data | input | 16 | Write data: masks in the upper byte, values in the lower byte |
| rd_data | output | 16 | Read data |
| req_in | input | NUM_REQ (4) | Incoming service requests |
| req_out | output | NUM_REQ (4) | Requests forwarded to the core |
| freeze_in | input | 1 | Debug host has frozen the system |
| core_stall | output | 1 | Stall the coprocessor core |
| sw_bkpt | input | 1 | Software breakpoint pulse |
| tag_bkpt | input | 1 | Tagged or forced breakpoint pulse |
| sw_err_evt | input | 1 | Software-error event pulse |
| dbg_mode | output | 1 | Debug-mode status |
| err_irq | output | 1 | Software-error interrupt |

## Verification
Every state change, whether from a write or from a pulse, appears on rd_data and dbg_mode one rising edge after the stimulus. req_out, core_stall and err_irq are combinational from the current state and the current inputs, so they follow a change in the inputs within the same cycle. The bench drives inputs at the falling edge. It checks the combinational outputs shortly after driving, against the state reached so far. It then checks rd_data at the next falling edge, against its own model advanced by one edge.

// File: rtl/cpctl_pkg.sv
package cpctl_pkg;

    localparam int CTRL_W   = 6;
    localparam int MASK_OFS = 8;

    localparam int B_ERR   = 0;
    localparam int B_FTEST = 1;
    localparam int B_IE    = 2;
    localparam int B_DBG   = 3;
    localparam int B_HIF   = 4;
    localparam int B_REN   = 5;

    // packed MSB first so that field order equals bit positions 5..0
    typedef struct packed {
        logic ren;
        logic hif;
        logic dbg;
        logic ie;
        logic ftest;
        logic err;
    } ctrl_t;

endpackage

// File: rtl/cpctl_wrdec.sv
module cpctl_wrdec
    import cpctl_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                  wr_en,
    input  logic [DATA_W/8-1:0]   wr_be,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [CTRL_W-1:0]     upd,
    output logic [CTRL_W-1:0]     val
);

    localparam int VAL_LANE  = 0;
    localparam int MASK_LANE = MASK_OFS / 8;

    logic lanes_ok;
    logic spare_unused;

    assign lanes_ok     = wr_en & wr_be[VAL_LANE] & wr_be[MASK_LANE];
    assign spare_unused = ^{wr_data, wr_be};

    for (genvar i = 0; i < CTRL_W; i++) begin : g_bit
        assign upd[i] = lanes_ok & wr_data[MASK_OFS + i];
        assign val[i] = wr_data[i];
    end

endmodule

// File: rtl/cpctl_bits.sv
module cpctl_bits
    import cpctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] upd,
    input  logic [CTRL_W-1:0] val,
    input  logic              err_set,
    input  logic              dbg_set,
    output ctrl_t             state_q
);

    ctrl_t state_d;

    always_comb begin
        state_d = state_q;
        if (upd[B_FTEST]) state_d.ftest = val[B_FTEST];
        if (upd[B_IE])    state_d.ie    = val[B_IE];
        if (upd[B_HIF])   state_d.hif   = val[B_HIF];
        if (upd[B_REN])   state_d.ren   = val[B_REN];
        // error flag: software may only clear, hardware set wins
        if (err_set)
            state_d.err = 1'b1;
        else if (upd[B_ERR] && !val[B_ERR])
            state_d.err = 1'b0;
        // debug: either breakpoint source wins over software
        if (dbg_set)
            state_d.dbg = 1'b1;
        else if (upd[B_DBG])
            state_d.dbg = val[B_DBG];
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    AST_IE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !upd[B_IE] |=> $stable(state_q.ie)); // R1
    AST_REN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !upd[B_REN] |=> $stable(state_q.ren)); // R1
    AST_ERR_NO_SWSET: assert property (@(posedge clk) disable iff (rst)
        (!err_set && !state_q.err) |=> !state_q.err); // R3
    AST_DBG_HW_SET: assert property (@(posedge clk) disable iff (rst)
        dbg_set |=> state_q.dbg); // R9
    AST_ERR_HW_SET: assert property (@(posedge clk) disable iff (rst)
        err_set |=> state_q.err); // R9
    AST_DBG_ONLY_WRITE_OR_BKPT: assert property (@(posedge clk) disable iff (rst)
        (!dbg_set && !upd[B_DBG]) |=> $stable(state_q.dbg)); // R8

endmodule

// File: rtl/cpctl_out.sv
module cpctl_out
    import cpctl_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  ctrl_t              state_q,
    input  logic [NUM_REQ-1:0] req_in,
    input  logic               freeze_in,
    output logic [NUM_REQ-1:0] req_out,
    output logic               core_stall,
    output logic               err_irq,
    output logic               dbg_mode,
    output logic [DATA_W-1:0]  rd_data
);

    for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
        assign req_out[r] = req_in[r] & state_q.ren;
    end

    assign core_stall = state_q.hif & freeze_in;
    assign err_irq    = state_q.err & state_q.ie;
    assign dbg_mode   = state_q.dbg;

    always_comb begin
        rd_data            = '0;
        rd_data[CTRL_W-1:0] = state_q;
    end

    AST_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !state_q.ren |-> (req_out == '0)); // R5
    AST_STALL_NEEDS_FREEZE: assert property (@(posedge clk) disable iff (rst)
        core_stall |-> freeze_in); // R6
    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
        err_irq |-> state_q.ie); // R10

endmodule

// File: rtl/cpctl_reg.sv
module cpctl_reg
    import cpctl_pkg::*;
#(
    parameter int NUM_REQ = 4,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [NUM_REQ-1:0] req_in,
    output logic [NUM_REQ-1:0] req_out,
    input  logic               freeze_in,
    output logic               core_stall,
    input  logic               sw_bkpt,
    input  logic               tag_bkpt,
    input  logic               sw_err_evt,
    output logic               dbg_mode,
    output logic               err_irq
);

    logic [CTRL_W-1:0] upd;
    logic [CTRL_W-1:0] val;
    logic              dbg_set;
    ctrl_t             state_q;

    assign dbg_set = sw_bkpt | tag_bkpt;

    cpctl_wrdec #(.DATA_W(DATA_W)) u_wrdec (
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .upd     (upd),
        .val     (val)
    );

    cpctl_bits u_bits (
        .clk     (clk),
        .rst     (rst),
        .upd     (upd),
        .val     (val),
        .err_set (sw_err_evt),
        .dbg_set (dbg_set),
        .state_q (state_q)
    );

    cpctl_out #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .state_q    (state_q),
        .req_in     (req_in),
        .freeze_in  (freeze_in),
        .req_out    (req_out),
        .core_stall (core_stall),
        .err_irq    (err_irq),
        .dbg_mode   (dbg_mode),
        .rd_data    (rd_data)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (rd_data == '0)); // R11
    AST_LANES_REQUIRED: assert property (@(posedge clk) disable iff (rst)
        (!dbg_set && !sw_err_evt && !(wr_en && wr_be == '1)) |=> $stable(rd_data)); // R12

endmodule

// File: tb/cpctl_reg_test.sv
module cpctl_reg_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data;
    logic [3:0]  req_in = 4'h0;
    logic [3:0]  req_out;
    logic        freeze_in = 1'b0;
    logic        core_stall;
    logic        sw_bkpt = 1'b0;
    logic        tag_bkpt = 1'b0;
    logic        sw_err_evt = 1'b0;
    logic        dbg_mode;
    logic        err_irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cpctl_reg uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .rd_data(rd_data), .req_in(req_in), .req_out(req_out),
        .freeze_in(freeze_in), .core_stall(core_stall), .sw_bkpt(sw_bkpt),
        .tag_bkpt(tag_bkpt), .sw_err_evt(sw_err_evt), .dbg_mode(dbg_mode),
        .err_irq(err_irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one access: drive at a falling edge, let one rising edge pass, go idle
    task automatic step(input logic we, input logic [1:0] be, input logic [15:0] d,
                        input logic sb, input logic tb, input logic se);
        @(negedge clk);
        wr_en = we; wr_be = be; wr_data = d;
        sw_bkpt = sb; tag_bkpt = tb; sw_err_evt = se;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00; wr_data = 16'h0;
        sw_bkpt = 1'b0; tag_bkpt = 1'b0; sw_err_evt = 1'b0;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [5:0] st;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        req_in = 4'hF;
        chk("R11 reset rd_data", rd_data, 16'h0000);
        chk("R5 gated after reset", {12'h0, req_out}, 16'h0000);

        // write all ones with both lanes: error flag must not set
        step(1, 2'b11, 16'hFFFF, 0, 0, 0);
        chk("R2 upper byte zero", rd_data, 16'h003E);
        chk("R3 write 1 no set", {15'h0, rd_data[0]}, 16'h0000);
        chk("R5 forwarded", {12'h0, req_out}, 16'h000F);

        // R12: one lane missing
        step(1, 2'b01, 16'h3F00, 0, 0, 0);
        chk("R12 value lane only", rd_data, 16'h003E);
        step(1, 2'b10, 16'h3F00, 0, 0, 0);
        chk("R12 mask lane only", rd_data, 16'h003E);

        // R4: clear interrupt-enable alone, then flag-test alone
        step(1, 2'b11, 16'h0400, 0, 0, 0);
        chk("R4 clear ie", rd_data, 16'h003A);
        step(1, 2'b11, 16'h0200, 0, 0, 0);
        chk("R4 clear ftest", rd_data, 16'h0038);
        step(1, 2'b11, 16'h0202, 0, 0, 0);
        chk("R4 set ftest", rd_data, 16'h003A);

        // R3 / R10: hardware sets flag; irq only with ie
        step(0, 2'b00, 16'h0000, 0, 0, 1);
        chk("R3 hw set", rd_data, 16'h003B);
        chk("R10 irq off without ie", {15'h0, err_irq}, 16'h0000);
        step(1, 2'b11, 16'h0404, 0, 0, 0);
        chk("R10 irq on", {15'h0, err_irq}, 16'h0001);
        step(1, 2'b11, 16'h0101, 0, 0, 0);
        chk("R3 masked 1 keeps", rd_data, 16'h003F);
        step(1, 2'b11, 16'h0100, 0, 0, 0);
        chk("R3 masked 0 clears", rd_data, 16'h003E);

        // R9: hardware set beats same-cycle masked clear
        step(1, 2'b11, 16'h0100, 0, 0, 1);
        chk("R9 err set wins", {15'h0, rd_data[0]}, 16'h0001);
        step(1, 2'b11, 16'h0800, 0, 1, 0);
        chk("R9 dbg set wins", {15'h0, dbg_mode}, 16'h0001);
        step(1, 2'b11, 16'h0800, 0, 0, 0);
        chk("R7 masked clear dbg", {15'h0, dbg_mode}, 16'h0000);
        step(0, 2'b00, 16'h0000, 1, 0, 0);
        chk("R7 sw breakpoint", {15'h0, dbg_mode}, 16'h0001);
        step(1, 2'b11, 16'h0800, 0, 0, 0);

        // R8 / R6: freeze and error event leave debug alone
        freeze_in = 1'b1;
        step(0, 2'b00, 16'h0000, 0, 0, 1);
        chk("R8 dbg unchanged", {15'h0, dbg_mode}, 16'h0000);
        chk("R6 stall", {15'h0, core_stall}, 16'h0001);
        step(1, 2'b11, 16'h1000, 0, 0, 0);
        chk("R6 no stall hif=0", {15'h0, core_stall}, 16'h0000);
        freeze_in = 1'b0;

        do_reset();
        chk("R11 reset clears", rd_data, 16'h0000);

        // sweep every mask x value x lane pattern with mixed events
        st = 6'h0;
        for (int m = 0; m < 64; m++) begin
            for (int v = 0; v < 64; v++) begin
                for (int b = 0; b < 4; b++) begin
                    logic we, se, sb, tb, fz;
                    logic [3:0] rq;
                    logic [5:0] upd;
                    logic [5:0] mm, vv;
                    mm = m[5:0]; vv = v[5:0];
                    @(negedge clk);
                    chk("R1 sweep rd_data", rd_data, {10'h0, st});
                    we = ((m + v + b) % 5) != 0;
                    se = ((m * 7 + v + b) % 9) == 0;
                    sb = ((m + v * 5 + b) % 13) == 0;
                    tb = ((m * 11 + v + b * 3) % 17) == 0;
                    fz = vv[1] ^ mm[4] ^ b[0];
                    rq = vv[3:0] ^ mm[3:0];
                    wr_en = we; wr_be = b[1:0]; wr_data = {2'b00, mm, 2'b00, vv};
                    sw_err_evt = se; sw_bkpt = sb; tag_bkpt = tb;
                    freeze_in = fz; req_in = rq;
                    #1;
                    chk("R5 sweep req_out", {12'h0, req_out}, {12'h0, st[5] ? rq : 4'h0});
                    chk("R6 sweep stall", {15'h0, core_stall}, {15'h0, st[4] & fz});
                    chk("R10 sweep irq", {15'h0, err_irq}, {15'h0, st[0] & st[2]});
                    chk("R7 sweep dbg", {15'h0, dbg_mode}, {15'h0, st[3]});
                    upd = (we && b == 3) ? mm : 6'h0;
                    for (int i = 1; i < 6; i++)
                        if (i != 3 && upd[i]) st[i] = vv[i];
                    if (se) st[0] = 1'b1;
                    else if (upd[0] && !vv[0]) st[0] = 1'b0;
                    if (sb || tb) st[3] = 1'b1;
                    else if (upd[3]) st[3] = vv[3];
                end
            end
        end
        @(negedge clk);
        chk("R1 sweep final", rd_data, {10'h0, st});
        wr_en = 1'b0; sw_err_evt = 1'b0; sw_bkpt = 1'b0; tag_bkpt = 1'b0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule